// File: doc/BRIEF.md
# Line-Stepped Two-Bit Transfer Sequencer

This block is a tiny data section run by a six-line control program. The control side is a ring of state flops, one per program line, with exactly one flop set at a time. Each set flop enables the register loads that belong to its line. The data side holds three words (A, B, C) of `DW` bits and a one-bit flag S.

The program loops as follows. A captures the input word. Next, C takes the inverse of A and S takes the lowest bit of A. Then B copies C, and C is rebuilt as A OR B. At that point the top bit of A picks one of two closing lines. One closing line sets S and the other clears it. Both closing lines put C on the output word and then jump back to the first line.

The output word is zero outside the two closing lines, and the flag output follows S at all times. The active line is brought out as a flag vector so that the surrounding logic, or a bench, can watch the control ring. All loads and line changes happen on one rising clock edge, using load enables and no derived clocks. The input word may change at any time. Only its value at the edge that ends line 1 is used.

Top module: `rtseq_core`

## Requirements
- R1: A synchronous active-high reset makes line 1 the only active line (`step_f` = 6'b000001) and clears A, B, C and S to zero. After that, `z_out` = 0 and `p_out` = 0.
- R2: After each clock edge exactly one bit of `step_f` is high. Bit i-1 marks line i. Lines 1, 2 and 3 are each followed by the next line.
- R3: The edge that ends line 1 loads A from `x_in`. `x_in` has no effect at any other line.
- R4: The edge that ends line 2 loads C with the bitwise inverse of A and loads S with A[0].
- R5: The edge that ends line 3 loads B from C. The edge that ends line 4 loads C with A OR B.
- R6: At the end of line 4, control goes to line 5 if A[DW-1] is 1 and to line 6 if it is 0.
- R7: The edge that ends line 5 sets S to 1. The edge that ends line 6 clears S to 0. Both edges return control to line 1.
- R8: `z_out` equals C while line 5 or line 6 is active and is all zeros otherwise.
- R9: `p_out` equals S in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high control reset |
| x_in | input | DW | Input word, sampled only when line 1 ends |
| z_out | output | DW | C during lines 5 and 6, zero otherwise |
| p_out | output | 1 | Mirror of flag register S |
| step_f | output | 6 | One-hot active-line flags, bit 0 = line 1 |

## Verification
The bench builds the block with the default `DW` = 2, so all four input words can be applied and both branch targets are reached. With this width, the low bit of A is visible on `p_out` during lines 3 and 4, and the high bit of A is visible through which closing line is taken. During every line other than line 1, the input is driven to the complement of the captured word, so a load at the wrong line would change what is observed. A reset issued in the middle of a pass checks that the ring and the registers restart cleanly.

// File: rtl/rtseq_pkg.sv
package rtseq_pkg;
  localparam int STEPS   = 6;
  localparam int L_LOAD  = 0;  // line 1: A <- X
  localparam int L_INV   = 1;  // line 2: C <- ~A, S <- A[0]
  localparam int L_COPY  = 2;  // line 3: B <- C
  localparam int L_MERGE = 3;  // line 4: C <- A | B, branch
  localparam int L_HI    = 4;  // line 5: Z = C, S <- 1
  localparam int L_LO    = 5;  // line 6: Z = C, S <- 0
  localparam logic [STEPS-1:0] RING_RESET = 6'b000001;
endpackage

// File: rtl/rtseq_ctrl.sv
module rtseq_ctrl
  import rtseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             br_bit,
  output logic [STEPS-1:0] step_q
);
  logic [STEPS-1:0] step_d;

  // straight-line part of the ring: lines 2..4 follow their predecessor
  for (genvar i = L_INV; i <= L_MERGE; i++) begin : g_chain
    assign step_d[i] = step_q[i-1];
  end

  // closing lines fan back in to line 1; line 4 forks on the branch bit
  assign step_d[L_LOAD] = step_q[L_HI] | step_q[L_LO];
  assign step_d[L_HI]   = step_q[L_MERGE] &  br_bit;
  assign step_d[L_LO]   = step_q[L_MERGE] & ~br_bit;

  always_ff @(posedge clk) begin
    if (rst) step_q <= RING_RESET;
    else     step_q <= step_d;
  end
endmodule

// File: rtl/rtseq_dpath.sv
module rtseq_dpath
  import rtseq_pkg::*;
#(
  parameter int DW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    x_in,
  input  logic [STEPS-1:0] step_q,
  output logic [DW-1:0]    a_q,
  output logic [DW-1:0]    b_q,
  output logic [DW-1:0]    c_q,
  output logic             s_q
);
  localparam int MSB = DW - 1;

  // C has two sources; the active line picks one
  function automatic logic [DW-1:0] c_source(input logic merge_sel,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    return merge_sel ? (a | b) : ~a;
  endfunction

  // S has three sources; the active line picks one
  function automatic logic s_source(input logic inv_sel, input logic hi_sel,
                                    input logic [DW-1:0] a);
    if (inv_sel)     return a[0];
    else if (hi_sel) return 1'b1;
    else             return 1'b0;
  endfunction

  logic          ld_a, ld_b, ld_c, ld_s;
  logic [DW-1:0] c_next;
  logic          s_next;

  assign ld_a   = step_q[L_LOAD];
  assign ld_b   = step_q[L_COPY];
  assign ld_c   = step_q[L_INV] | step_q[L_MERGE];
  assign ld_s   = step_q[L_INV] | step_q[L_HI] | step_q[L_LO];
  assign c_next = c_source(step_q[L_MERGE], a_q, b_q);
  assign s_next = s_source(step_q[L_INV], step_q[L_HI], a_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
      s_q <= 1'b0;
    end else begin
      if (ld_a) a_q <= x_in;
      if (ld_b) b_q <= c_q;
      if (ld_c) c_q <= c_next;
      if (ld_s) s_q <= s_next;
    end
  end

  logic unused_msb;
  assign unused_msb = a_q[MSB] & 1'b0;
endmodule

// File: rtl/rtseq_zdrv.sv
module rtseq_zdrv #(
  parameter int DW = 2
) (
  input  logic          out_en,
  input  logic [DW-1:0] c_q,
  output logic [DW-1:0] z_out
);
  assign z_out = c_q & {DW{out_en}};
endmodule

// File: rtl/rtseq_core.sv
module rtseq_core
  import rtseq_pkg::*;
#(
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] x_in,
  output logic [DW-1:0] z_out,
  output logic          p_out,
  output logic [5:0]    step_f
);
  logic [STEPS-1:0] step_q;
  logic [DW-1:0]    a_q, b_q, c_q;
  logic             s_q;
  logic             br_bit;
  logic             out_en;

  assign br_bit = a_q[DW-1];
  assign out_en = step_q[L_HI] | step_q[L_LO];

  rtseq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .br_bit (br_bit),
    .step_q (step_q)
  );

  rtseq_dpath #(.DW(DW)) u_dpath (
    .clk    (clk),
    .rst    (rst),
    .x_in   (x_in),
    .step_q (step_q),
    .a_q    (a_q),
    .b_q    (b_q),
    .c_q    (c_q),
    .s_q    (s_q)
  );

  rtseq_zdrv #(.DW(DW)) u_zdrv (
    .out_en (out_en),
    .c_q    (c_q),
    .z_out  (z_out)
  );

  assign p_out  = s_q;
  assign step_f = step_q;
endmodule

// File: rtl/rtseq_chk.sv
module rtseq_chk
  import rtseq_pkg::*;
#(
  parameter int DW = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [DW-1:0]    x_in,
  input logic [STEPS-1:0] step_q,
  input logic [DW-1:0]    a_q,
  input logic [DW-1:0]    b_q,
  input logic [DW-1:0]    c_q,
  input logic             s_q,
  input logic [DW-1:0]    z_out
);
  logic rst_d;

  // R1: one edge after a reset edge the ring and registers are at rest
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_reset_state_R1: assert (step_q == RING_RESET && a_q == '0 &&
                                     b_q == '0 && c_q == '0 && !s_q)
        else $error("reset state wrong");
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(step_q) == 1);

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    step_q[L_LOAD] |=> a_q == $past(x_in));

  assert_invert_R4: assert property (@(posedge clk) disable iff (rst)
    step_q[L_INV] |=> (c_q == ~$past(a_q)) && (s_q == $past(a_q[0])));

  assert_merge_R5: assert property (@(posedge clk) disable iff (rst)
    step_q[L_MERGE] |=> &c_q);

  assert_branch_hi_R6: assert property (@(posedge clk) disable iff (rst)
    (step_q[L_MERGE] && a_q[DW-1]) |=> step_q[L_HI]);

  assert_branch_lo_R6: assert property (@(posedge clk) disable iff (rst)
    (step_q[L_MERGE] && !a_q[DW-1]) |=> step_q[L_LO]);

  assert_close_hi_R7: assert property (@(posedge clk) disable iff (rst)
    step_q[L_HI] |=> s_q && step_q[L_LOAD]);

  assert_close_lo_R7: assert property (@(posedge clk) disable iff (rst)
    step_q[L_LO] |=> !s_q && step_q[L_LOAD]);

  assert_z_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (step_q[L_LOAD] || step_q[L_INV]) |-> z_out == '0);
endmodule

bind rtseq_core rtseq_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .x_in   (x_in),
  .step_q (step_q),
  .a_q    (a_q),
  .b_q    (b_q),
  .c_q    (c_q),
  .s_q    (s_q),
  .z_out  (z_out)
);

// File: tb/rtseq_core_tb.sv
module rtseq_core_tb;
  localparam int DW = 2;

  typedef struct {
    logic [5:0]    flags;
    logic [DW-1:0] z;
    logic          p;
    int            ftag;
    int            ztag;
    int            ptag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] x_in = '0;
  logic [DW-1:0] z_out;
  logic          p_out;
  logic [5:0]    step_f;

  int   n_checks = 0;
  int   n_fail   = 0;
  exp_t exp_q[$];
  event sample_ev;

  // reference state, kept in the bench's own terms
  int            m_line;
  logic [DW-1:0] m_a, m_b, m_c;
  logic          m_s;
  logic          m_fresh;   // first sample after a reset
  int            m_prev;    // line of the previous sample

  always #10 clk = ~clk;  // 50 MHz

  rtseq_core #(.DW(DW)) u_dut (
    .clk    (clk),
    .rst    (rst),
    .x_in   (x_in),
    .z_out  (z_out),
    .p_out  (p_out),
    .step_f (step_f)
  );

  function automatic string tname(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_line = 1; m_a = '0; m_b = '0; m_c = '0; m_s = 1'b0;
    m_fresh = 1'b1; m_prev = 0;
  endtask

  // one cycle: record what must be seen now, then apply inputs for the coming edge
  task automatic cycle(input logic [DW-1:0] xv, input logic rv);
    exp_t e;
    @(negedge clk);
    e.flags = 6'(1 << (m_line - 1));
    e.z     = (m_line >= 5) ? m_c : '0;
    e.p     = m_s;
    if (m_fresh) begin
      e.ftag = 1; e.ztag = 1; e.ptag = 1;            // R1
    end else begin
      e.ftag = (m_line >= 5) ? 6 : 2;                 // R6 branch / R2 chain
      e.ztag = (m_line >= 5) ? 5 : 8;                 // R5 value / R8 quiet
      if (m_line == 3)                    e.ptag = 4; // R4 S from A[0]
      else if (m_line == 4)               e.ptag = 3; // R3 captured word
      else if (m_line == 1 && m_prev >= 5) e.ptag = 7; // R7 close
      else                                e.ptag = 9; // R9 mirror
    end
    exp_q.push_back(e);
    ->sample_ev;
    x_in = xv;
    rst  = rv;
    m_prev  = m_line;
    m_fresh = 1'b0;
    if (rv) begin
      model_reset();
    end else begin
      case (m_line)
        1: begin m_a = xv; m_line = 2; end
        2: begin m_c = ~m_a; m_s = m_a[0]; m_line = 3; end
        3: begin m_b = m_c; m_line = 4; end
        4: begin m_c = m_a | m_b; m_line = m_a[DW-1] ? 5 : 6; end
        5: begin m_s = 1'b1; m_line = 1; end
        default: begin m_s = 1'b0; m_line = 1; end
      endcase
    end
  endtask

  // one pass of the program: the word at line 1, its complement elsewhere
  task automatic run_pass(input logic [DW-1:0] w);
    for (int k = 0; k < 5; k++) begin
      cycle((m_line == 1) ? w : ~w, 1'b0);
    end
  endtask

  // monitor: pop and compare each expected item
  initial begin
    forever begin
      exp_t e;
      @(sample_ev);
      #1;
      e = exp_q.pop_front();
      n_checks++;
      if (step_f !== e.flags) begin
        n_fail++;
        $display("FAIL %s step_f actual=%b expected=%b", tname(e.ftag), step_f, e.flags);
      end
      n_checks++;
      if (z_out !== e.z) begin
        n_fail++;
        $display("FAIL %s z_out actual=%b expected=%b", tname(e.ztag), z_out, e.z);
      end
      n_checks++;
      if (p_out !== e.p) begin
        n_fail++;
        $display("FAIL %s p_out actual=%b expected=%b", tname(e.ptag), p_out, e.p);
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    // walk all input words, each twice, to reach both branch targets
    for (int r = 0; r < 2; r++) begin
      for (int w = 0; w < 4; w++) run_pass(DW'(w));
    end
    // reset in the middle of a pass (R1), then resume
    cycle(2'b11, 1'b0);
    cycle(2'b00, 1'b0);
    cycle(2'b00, 1'b1);
    run_pass(2'b10);
    run_pass(2'b01);
    cycle(2'b00, 1'b0);
    @(negedge clk);
    #2;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule